// File: doc/BRIEF.md
# Multi-Core Power-Gating Sequencer

This block sequences the power partitions of a small cluster of processor cores. Each core has its own control/status word on a simple register bus. Software arms a core by setting its enable bit and the core's own bit in a one-hot WFI mask. When that core then pulses its wait-for-interrupt strobe, the sequencer asserts the core's reset and removes partition power once a fixed settle time has elapsed.

A wake request written together with enable reverses the process. Power is restored after the same settle time, and the core leaves reset one cycle after its status reads "on". Hardware clears the wake request once it has been acted on. Each core also has a halt-mode word; one specific code value holds that core halted. A read-only status bit in each control/status word shows whether the partition is currently powered.

Software typically brings every secondary core under the sequencer's control once. After that, it turns cores on and off only through their control/status words.

Top module: `pgc_flow_ctrl`

## Requirements
- R1: After reset, core 0 is powered (`core_pwr_en[0]`=1, `core_rst[0]`=0) and cores 1 to 3 are unpowered and held in reset. Every stored field reads zero, so core 0's word reads 0x0001_0000 and cores 1 to 3 read zero.
- R2: The control/status word has these fields: enable at bit 0, wake request at bit 3, WFI mask at bits 8+n (one bit per core n), and the power status at bit 16. Enable and the mask read back as written. Bit 16 is read-only and writes to it are ignored.
- R3: Control/status words sit at byte offset 0x08 for core 0 and at 0x18, 0x20 and 0x28 for cores 1, 2 and 3. Halt-mode words sit at 0x00, 0x14, 0x1C and 0x24 for cores 0 to 3.
- R4: If a powered core has enable=1 and its own mask bit set, a WFI strobe sampled at clock edge E0 asserts its reset at E1 and drops its power enable and status at E4.
- R5: The mask is one-hot per core, not a core number. A WFI strobe on core n does not change its power when only mask bits other than bit 8+n are set.
- R6: With enable=0, a WFI strobe has no effect on power, even when the core's own mask bit is set.
- R7: Writing enable and wake together to an unpowered core at edge W raises its power enable and status at W+5 and releases its reset at W+6. A core without power always has its reset asserted.
- R8: A WFI strobe on a core that is already unpowered is ignored, and the core stays off.
- R9: A halt-mode word stores bits 31:29 and reads back only those bits. The core's halt output is 1 exactly when this field holds 3'b010.
- R10: Writes to offsets that hold no register have no effect, and reads from them return zero.
- R11: Hardware clears the wake bit one cycle after it has been acted on. A wake request to a core that is already powered is cleared without any power change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_wfi | input | 4 | Per-core wait-for-interrupt strobes |
| core_pwr_en | output | 4 | Per-core partition power enable |
| core_rst | output | 4 | Per-core reset, active high |
| core_halt | output | 4 | Per-core halt request |

## Verification
A sequencer stuck in its settling state shows up at the ports as a status bit and power enable that never change, or that change off the fourth edge after their trigger. The bench therefore samples in the cycles just before and just after each expected edge. A wrongly retained wake bit appears on the very next register read. A mis-decoded offset corrupts a neighbouring core's word, which the readback pass and the later re-read expose at once. A reset released early appears as `core_rst` low while `core_pwr_en` is still low, and this is visible in the same cycle.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    // control/status word field positions
    localparam int EN_BIT   = 0;
    localparam int WAKE_BIT = 3;
    localparam int MASK_LSB = 8;
    localparam int STAT_BIT = 16;
    // halt-mode field
    localparam int          HALT_LSB  = 29;
    localparam logic [2:0]  HALT_STOP = 3'd2;

    // byte offset of the control/status word of core n
    function automatic int csr_offset(input int n);
        return (n == 0) ? 'h08 : 'h18 + 8 * (n - 1);
    endfunction

    // byte offset of the halt-mode word of core n
    function automatic int halt_offset(input int n);
        return (n == 0) ? 'h00 : 'h14 + 8 * (n - 1);
    endfunction
endpackage

// File: rtl/pgc_addr_decode.sv
module pgc_addr_decode #(
    parameter int NCORES = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCORES-1:0] csr_hit,
    output logic [NCORES-1:0] halt_hit
);
    for (genvar i = 0; i < NCORES; i++) begin : g_dec
        assign csr_hit[i]  = (addr == ADDR_W'(pgc_pkg::csr_offset(i)));
        assign halt_hit[i] = (addr == ADDR_W'(pgc_pkg::halt_offset(i)));
    end
endmodule

// File: rtl/pgc_core_seq.sv
module pgc_core_seq #(
    parameter int   NCORES       = 4,
    parameter int   CORE_IDX     = 0,
    parameter int   SETTLE       = 4,
    parameter logic PWR_AT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic              halt_we,
    input  logic              wr_en,
    input  logic              wr_wake,
    input  logic [NCORES-1:0] wr_mask,
    input  logic [2:0]        wr_halt,
    input  logic              wfi,
    output logic [31:0]       csr_rd,
    output logic [31:0]       halt_rd,
    output logic              pwr_en,
    output logic              core_rst,
    output logic              core_halt
);
    import pgc_pkg::*;

    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

    typedef struct packed {
        logic              en;
        logic              wake;
        logic [NCORES-1:0] mask;
        logic [2:0]        halt_mode;
        logic              pwr;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              rst;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.busy = 1'b0;
                s_d.pwr  = !s_q.pwr;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (s_q.en && s_q.wake) begin
            s_d.wake = 1'b0;
            if (!s_q.pwr) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
            end
        end else if (s_q.en && s_q.mask[CORE_IDX] && wfi && s_q.pwr) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
        // reset held unless settled in the powered state
        s_d.rst = !(s_q.pwr && !s_q.busy);
        // software write takes precedence over the hardware clear
        if (csr_we) begin
            s_d.en   = wr_en;
            s_d.wake = wr_wake;
            s_d.mask = wr_mask;
        end
        if (halt_we) s_d.halt_mode = wr_halt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pwr <= PWR_AT_RESET;
            s_q.rst <= !PWR_AT_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        csr_rd                    = '0;
        csr_rd[EN_BIT]            = s_q.en;
        csr_rd[WAKE_BIT]          = s_q.wake;
        csr_rd[MASK_LSB +: NCORES] = s_q.mask;
        csr_rd[STAT_BIT]          = s_q.pwr;
        halt_rd                   = '0;
        halt_rd[HALT_LSB +: 3]    = s_q.halt_mode;
    end

    assign pwr_en    = s_q.pwr;
    assign core_rst  = s_q.rst;
    assign core_halt = (s_q.halt_mode == HALT_STOP);

    // power changes only at the end of a full settle window
    p_settle_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_en) |-> $past(s_q.busy && s_q.cnt == CNT_LAST));

    // an unpowered core is always held in reset
    p_off_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> core_rst);

    // reset is released only after power has been up for a cycle
    p_rst_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (pwr_en && $past(pwr_en)));

    // an idle unpowered core cannot regain power in one step
    p_off_stays_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !s_q.busy) |=> !pwr_en);

    // a serviced wake request is cleared
    p_wake_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && s_q.wake && !s_q.busy && !csr_we) |=> !s_q.wake);
endmodule

// File: rtl/pgc_flow_ctrl.sv
module pgc_flow_ctrl #(
    parameter int          NCORES       = 4,
    parameter int          ADDR_W       = 8,
    parameter int          SETTLE       = 4,
    parameter logic [3:0]  PWR_AT_RESET = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [NCORES-1:0] core_wfi,
    output logic [NCORES-1:0] core_pwr_en,
    output logic [NCORES-1:0] core_rst,
    output logic [NCORES-1:0] core_halt
);
    import pgc_pkg::*;

    logic [NCORES-1:0] csr_hit, halt_hit;
    logic [31:0]       csr_rd  [NCORES];
    logic [31:0]       halt_rd [NCORES];

    pgc_addr_decode #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .csr_hit  (csr_hit),
        .halt_hit (halt_hit)
    );

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        pgc_core_seq #(
            .NCORES       (NCORES),
            .CORE_IDX     (i),
            .SETTLE       (SETTLE),
            .PWR_AT_RESET (PWR_AT_RESET[i])
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .csr_we    (bus_we && csr_hit[i]),
            .halt_we   (bus_we && halt_hit[i]),
            .wr_en     (bus_wdata[EN_BIT]),
            .wr_wake   (bus_wdata[WAKE_BIT]),
            .wr_mask   (bus_wdata[MASK_LSB +: NCORES]),
            .wr_halt   (bus_wdata[HALT_LSB +: 3]),
            .wfi       (core_wfi[i]),
            .csr_rd    (csr_rd[i]),
            .halt_rd   (halt_rd[i]),
            .pwr_en    (core_pwr_en[i]),
            .core_rst  (core_rst[i]),
            .core_halt (core_halt[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (csr_hit[i])  bus_rdata = bus_rdata | csr_rd[i];
            if (halt_hit[i]) bus_rdata = bus_rdata | halt_rd[i];
        end
    end

    // at most one register is selected by any offset
    p_decode_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({csr_hit, halt_hit}));
endmodule

// File: tb/tb_pgc_flow_ctrl.sv
module tb_pgc_flow_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_wfi = '0;
    logic [3:0]  core_pwr_en, core_rst, core_halt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pgc_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .core_wfi(core_wfi),
        .core_pwr_en(core_pwr_en), .core_rst(core_rst), .core_halt(core_halt)
    );

    // {offset, write data, expected readback}
    localparam logic [71:0] VEC [0:10] = '{
        {8'h08, 32'h0000_0301, 32'h0001_0301}, // R2 core0, status on
        {8'h18, 32'h0000_0201, 32'h0000_0201}, // R3 core1 own mask bit
        {8'h20, 32'hFFFF_F0F6, 32'h0000_0000}, // R2 status bit not writable
        {8'h28, 32'h0001_0801, 32'h0000_0801}, // R3 core3
        {8'h00, 32'h4000_0000, 32'h4000_0000}, // R9 halt core0 stop
        {8'h14, 32'hFFFF_FFFF, 32'hE000_0000}, // R9 only bits 31:29 kept
        {8'h1C, 32'h5000_0000, 32'h4000_0000}, // R9 halt core2 stop
        {8'h24, 32'h2000_0000, 32'h2000_0000}, // R9 halt core3 other code
        {8'h04, 32'hFFFF_FFFF, 32'h0000_0000}, // R10 hole
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000}, // R10 hole
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0000}  // R10 hole
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wfi_pulse(input int n);
        @(negedge clk);
        core_wfi[n] = 1'b1;
        @(negedge clk);
        core_wfi = '0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 pwr", 32'(core_pwr_en), 32'h1);
        chk("R1 rst", 32'(core_rst), 32'hE);
        chk("R1 halt", 32'(core_halt), 32'h0);
        bus_read(8'h08, rd); chk("R1 core0 word", rd, 32'h0001_0000);
        bus_read(8'h18, rd); chk("R1 core1 word", rd, 32'h0);

        // R2 R3 R9 R10 table walk
        for (int i = 0; i < 11; i++) begin
            bus_write(VEC[i][71:64], VEC[i][63:32]);
            bus_read(VEC[i][71:64], rd);
            chk("R2/R3/R9/R10 readback", rd, VEC[i][31:0]);
        end
        bus_read(8'h08, rd); chk("R10 core0 untouched", rd, 32'h0001_0301);
        bus_read(8'h20, rd); chk("R10 core2 untouched", rd, 32'h0);
        chk("R9 halt outputs", 32'(core_halt), 32'h5);

        // R4 gate core0 (enable + mask bit0 set)
        wfi_pulse(0);
        step(1);
        chk("R4 rst at E1", 32'(core_rst[0]), 32'h1);
        chk("R4 pwr kept at E1", 32'(core_pwr_en[0]), 32'h1);
        step(2);
        chk("R4 pwr kept at E3", 32'(core_pwr_en[0]), 32'h1);
        step(1);
        chk("R4 pwr off at E4", 32'(core_pwr_en[0]), 32'h0);
        bus_read(8'h08, rd); chk("R4 status off", rd, 32'h0000_0301);
        chk("R4 other cores", 32'(core_pwr_en[3:1]), 32'h0);

        // R7 wake core2
        bus_write(8'h20, 32'h0000_0009);
        step(4);
        chk("R7 pwr still off at W+4", 32'(core_pwr_en[2]), 32'h0);
        step(1);
        chk("R7 pwr on at W+5", 32'(core_pwr_en[2]), 32'h1);
        chk("R7 rst held at W+5", 32'(core_rst[2]), 32'h1);
        step(1);
        chk("R7 rst released at W+6", 32'(core_rst[2]), 32'h0);
        bus_read(8'h20, rd); chk("R11 wake cleared", rd, 32'h0001_0001);

        // R5 mask holding a core number, not own bit
        bus_write(8'h20, 32'h0000_0201);
        wfi_pulse(2);
        step(8);
        chk("R5 wrong mask ignored", 32'(core_pwr_en[2]), 32'h1);

        // R6 enable clear
        bus_write(8'h20, 32'h0000_0400);
        wfi_pulse(2);
        step(8);
        chk("R6 disabled ignored", 32'(core_pwr_en[2]), 32'h1);

        // R4 second pattern on core2
        bus_write(8'h20, 32'h0000_0401);
        wfi_pulse(2);
        step(3);
        chk("R4 core2 on at E3", 32'(core_pwr_en[2]), 32'h1);
        step(1);
        chk("R4 core2 off at E4", 32'(core_pwr_en[2]), 32'h0);

        // R8 strobe while gated
        wfi_pulse(2);
        step(8);
        chk("R8 stays off", 32'(core_pwr_en[2]), 32'h0);
        chk("R8 stays in reset", 32'(core_rst[2]), 32'h1);
        bus_read(8'h20, rd); chk("R8 status off", rd, 32'h0000_0401);

        // R11 wake core0, then wake again while powered
        bus_write(8'h08, 32'h0000_0309);
        step(6);
        chk("R7 core0 back on", 32'(core_pwr_en[0]), 32'h1);
        bus_write(8'h08, 32'h0000_0009);
        step(1);
        bus_read(8'h08, rd); chk("R11 wake cleared while on", rd, 32'h0001_0001);
        step(6);
        chk("R11 no power change", 32'(core_pwr_en[0]), 32'h1);
        chk("R11 no reset", 32'(core_rst[0]), 32'h0);

        summary();
    end
endmodule